// File: doc/BRIEF.md
# Cascadable Bidirectional Column Line Loader

This block collects one display line of pixel values for a column driver that sits in a chain with other identical drivers. The chain is started by a one- or two-cycle start pulse on whichever cascade pin a direction strap has made the input. Each accepted pixel carries three colour sub-pixels and fills the next pixel slot. The strap decides whether the slots fill upward from the first column or downward from the last. When the final slot is written, the block raises its output cascade pin in that same cycle, so the next driver in the chain takes the following pixel.

A filled line stays in a shadow buffer until a separate load strobe rises. That edge copies the whole buffer into an output latch that feeds the converters. The same edge samples a polarity input. The polarity sampled on one strobe is applied to the line latched by the next strobe. The applied polarity splits the columns into alternating high and low reference groups. Pixels that arrive with no load in progress are dropped, and a fresh start pulse in the middle of a line restarts the fill at the first slot.

Top module: `col_line_loader`

## Requirements
- R1: After synchronous reset, `line_q` is all zero, the applied polarity is low (so `col_hi` is 0 on columns with an even index and 1 on columns with an odd index), no load is in progress, and neither cascade output is high.
- R2: When `dir_fwd` is 1, `dio_a_in` is the start input and `dio_b_out` is the cascade output (`dio_b_oe`=1, `dio_a_oe`=0). When `dir_fwd` is 0, the roles swap. A pulse on the pin that is not the input starts nothing, and the unused output pin stays 0.
- R3: A load starts on the clock edge where the selected input pin is first sampled high. A pixel presented on that same edge is ignored, and the next accepted pixel fills slot 0. A start pulse may last one or two cycles without restarting the fill twice.
- R4: With the fill direction 1 (taken from `dir_fwd` at the start edge), the k-th accepted pixel (k from 0) fills pixel position k. Pixel position p drives columns 3p, 3p+1 and 3p+2 with the top, middle and bottom `DATA_W` fields of `pix_data`. Column c occupies `line_q[c*DATA_W +: DATA_W]`.
- R5: With the fill direction 0, the k-th accepted pixel fills pixel position `NUM_PIX-1-k`, and the sub-pixel order inside a position is the same as in R4.
- R6: The active cascade output is high only in the cycle where the pixel for the final slot is presented with `pix_valid` high during a load. It lasts one cycle, and the load ends on that edge.
- R7: Pixels presented while no load is in progress change neither the shadow buffer nor the cascade outputs.
- R8: A new start pulse during a load restarts the fill at slot 0.
- R9: Only a rising edge of `ld_strobe` copies the shadow buffer into `line_q`. `line_q` holds its value at all other times, including while the strobe stays high.
- R10: `pol_in` is sampled on each rising edge of `ld_strobe`. The value sampled on one rising edge becomes the applied polarity on the next rising edge. `col_hi` changes only on those edges.
- R11: For column index c, `col_hi[c]` equals the applied polarity when c is even (an odd-numbered column counted from 1) and its inverse when c is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | Direction strap: 1 fills from the first column and uses pin A as input |
| dio_a_in | input | 1 | Cascade pin A, input side |
| dio_b_in | input | 1 | Cascade pin B, input side |
| dio_a_out | output | 1 | Cascade pin A, output value |
| dio_b_out | output | 1 | Cascade pin B, output value |
| dio_a_oe | output | 1 | Cascade pin A output enable |
| dio_b_oe | output | 1 | Cascade pin B output enable |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_data | input | 3*DATA_W | Three sub-pixel codes, first column's code in the top field |
| ld_strobe | input | 1 | Line load strobe; its rising edge latches the line and samples polarity |
| pol_in | input | 1 | Polarity input sampled by the strobe |
| line_q | output | 3*NUM_PIX*DATA_W | Latched line, one DATA_W field per column |
| col_hi | output | 3*NUM_PIX | Per-column reference select, 1 = high reference set |

## Verification
The assertions watch the cascade pins on every cycle: exactly one pin is enabled as an output, the enabled pin matches the strap, the cascade pulse appears only with a presented pixel and never lasts two cycles, and the latched line and the column selects move only on a strobe rising edge. They cannot show where each pixel lands, that a pixel on the start edge or outside a load is dropped, that a restart returns to slot 0, or that polarity lags by exactly one line. The bench shows these by filling lines in both directions with one- and two-cycle start pulses, gaps between pixels, stray pixels, a pulse on the wrong pin and a strobe held high. It then compares every latched column and every select bit with values computed from the requirements.

// File: rtl/cld_pkg.sv
package cld_pkg;

    // Colour sub-pixels carried by one pixel word.
    localparam int CLD_SUBPIX = 3;
    // Default code width of one sub-pixel.
    localparam int CLD_DW     = 6;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_LOAD = 1'b1
    } seq_state_e;

    // Cascade-side events handed from the pin logic to the sequencer.
    typedef struct packed {
        logic start;   // first sampled-high cycle of the selected input pin
        logic fire;    // final slot being written this cycle
    } casc_ev_t;

    // Physical pixel position for fill slot 'slot' given the fill order.
    function automatic int unsigned cld_slot_pos(input logic fwd,
                                                 input int unsigned slot,
                                                 input int unsigned last);
        return fwd ? slot : (last - slot);
    endfunction

    // Reference-group select for a zero-based column index.
    function automatic logic cld_col_sel(input logic pol, input int unsigned col);
        return ((col % 2) == 0) ? pol : ~pol;
    endfunction

endpackage

// File: rtl/cld_cascade_io.sv
module cld_cascade_io
    import cld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dir_fwd,
    input  logic dio_a_in,
    input  logic dio_b_in,
    input  logic fire,
    output logic start,
    output logic dio_a_out,
    output logic dio_b_out,
    output logic dio_a_oe,
    output logic dio_b_oe
);

    logic sel_in;
    logic sel_prev;

    // The strap chooses which pin listens and which pin talks.
    assign sel_in = dir_fwd ? dio_a_in : dio_b_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= 1'b0;
        end else begin
            sel_prev <= sel_in;
        end
    end

    // Edge detect so a two-cycle pulse starts only one fill.
    assign start = sel_in & ~sel_prev;

    always_comb begin
        dio_a_oe  = ~dir_fwd;
        dio_b_oe  = dir_fwd;
        dio_a_out = ~dir_fwd & fire;
        dio_b_out = dir_fwd & fire;
    end

endmodule

// File: rtl/cld_slot_seq.sv
module cld_slot_seq
    import cld_pkg::*;
#(
    parameter int NUM_PIX = 160,
    localparam int AW     = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_fwd,
    input  logic          pix_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_pos,
    output logic          fire
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(NUM_PIX - 1);

    seq_state_e    state;
    logic [AW-1:0] slot;
    logic          fwd_q;
    logic          at_last;

    always_comb begin
        at_last = (slot == LAST_SLOT);
        // A pixel on the start edge belongs to no line yet.
        wr_en   = (state == SEQ_LOAD) && pix_valid && !start;
        fire    = wr_en && at_last;
        wr_pos  = AW'(cld_slot_pos(fwd_q, int'(slot), int'(LAST_SLOT)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            slot  <= '0;
            fwd_q <= 1'b1;
        end else if (start) begin
            state <= SEQ_LOAD;
            slot  <= '0;
            fwd_q <= dir_fwd;
        end else if (wr_en) begin
            if (at_last) begin
                state <= SEQ_IDLE;
                slot  <= '0;
            end else begin
                slot  <= slot + AW'(1);
            end
        end
    end

endmodule

// File: rtl/cld_line_store.sv
module cld_line_store
    import cld_pkg::*;
#(
    parameter int NUM_PIX  = 160,
    parameter int DATA_W   = CLD_DW,
    localparam int AW      = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
    localparam int PIX_W   = CLD_SUBPIX * DATA_W,
    localparam int NUM_COL = CLD_SUBPIX * NUM_PIX
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_pos,
    input  logic [PIX_W-1:0]          pix_data,
    input  logic                      copy,
    output logic [NUM_COL*DATA_W-1:0] line_q
);

    for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
        logic [PIX_W-1:0] shadow;
        logic [PIX_W-1:0] held;
        logic             hit;

        assign hit = wr_en && (wr_pos == AW'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow <= '0;
            end else if (hit) begin
                shadow <= pix_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                held <= '0;
            end else if (copy) begin
                held <= shadow;
            end
        end

        // Top field of the pixel word goes to the lowest column of the position.
        for (genvar s = 0; s < CLD_SUBPIX; s++) begin : g_sub
            assign line_q[(CLD_SUBPIX*p + s)*DATA_W +: DATA_W] =
                held[(CLD_SUBPIX-1-s)*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/cld_pol_map.sv
module cld_pol_map
    import cld_pkg::*;
#(
    parameter int NUM_COL = 480
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_strobe,
    input  logic               pol_in,
    output logic               copy,
    output logic [NUM_COL-1:0] col_hi
);

    logic ld_prev;
    logic pol_next;
    logic pol_cur;

    // The previous strobe level follows the pin even in reset, so a
    // strobe held high through reset does not look like a fresh edge.
    always_ff @(posedge clk) begin
        ld_prev <= ld_strobe;
    end

    assign copy = ld_strobe & ~ld_prev;

    // Two-stage polarity: sampled on one strobe, applied on the next.
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_next <= 1'b0;
            pol_cur  <= 1'b0;
        end else if (copy) begin
            pol_next <= pol_in;
            pol_cur  <= pol_next;
        end
    end

    for (genvar c = 0; c < NUM_COL; c++) begin : g_col
        assign col_hi[c] = cld_col_sel(pol_cur, c);
    end

endmodule

// File: rtl/col_line_loader.sv
module col_line_loader
    import cld_pkg::*;
#(
    parameter int NUM_PIX  = 160,
    parameter int DATA_W   = CLD_DW,
    localparam int AW      = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
    localparam int PIX_W   = CLD_SUBPIX * DATA_W,
    localparam int NUM_COL = CLD_SUBPIX * NUM_PIX
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dir_fwd,
    input  logic                      dio_a_in,
    input  logic                      dio_b_in,
    output logic                      dio_a_out,
    output logic                      dio_b_out,
    output logic                      dio_a_oe,
    output logic                      dio_b_oe,
    input  logic                      pix_valid,
    input  logic [PIX_W-1:0]          pix_data,
    input  logic                      ld_strobe,
    input  logic                      pol_in,
    output logic [NUM_COL*DATA_W-1:0] line_q,
    output logic [NUM_COL-1:0]        col_hi
);

    initial begin
        if (NUM_PIX < 2) $error("col_line_loader: NUM_PIX must be at least 2");
    end

    casc_ev_t      ev;
    logic          wr_en;
    logic [AW-1:0] wr_pos;
    logic          copy;

    cld_cascade_io u_io (
        .clk       (clk),
        .rst       (rst),
        .dir_fwd   (dir_fwd),
        .dio_a_in  (dio_a_in),
        .dio_b_in  (dio_b_in),
        .fire      (ev.fire),
        .start     (ev.start),
        .dio_a_out (dio_a_out),
        .dio_b_out (dio_b_out),
        .dio_a_oe  (dio_a_oe),
        .dio_b_oe  (dio_b_oe)
    );

    cld_slot_seq #(.NUM_PIX(NUM_PIX)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (ev.start),
        .dir_fwd   (dir_fwd),
        .pix_valid (pix_valid),
        .wr_en     (wr_en),
        .wr_pos    (wr_pos),
        .fire      (ev.fire)
    );

    cld_line_store #(.NUM_PIX(NUM_PIX), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_pos   (wr_pos),
        .pix_data (pix_data),
        .copy     (copy),
        .line_q   (line_q)
    );

    cld_pol_map #(.NUM_COL(NUM_COL)) u_pol (
        .clk       (clk),
        .rst       (rst),
        .ld_strobe (ld_strobe),
        .pol_in    (pol_in),
        .copy      (copy),
        .col_hi    (col_hi)
    );

endmodule

// File: rtl/col_line_loader_chk.sv
module col_line_loader_chk #(
    parameter int NUM_PIX = 160,
    parameter int DATA_W  = 6,
    localparam int NUM_COL = 3 * NUM_PIX
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      dir_fwd,
    input logic                      dio_a_out,
    input logic                      dio_b_out,
    input logic                      dio_a_oe,
    input logic                      dio_b_oe,
    input logic                      pix_valid,
    input logic                      ld_strobe,
    input logic [NUM_COL*DATA_W-1:0] line_q,
    input logic [NUM_COL-1:0]        col_hi
);

    logic any_out;
    assign any_out = dio_a_out | dio_b_out;

    // R2: exactly one cascade pin drives.
    p_one_driver_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({dio_a_oe, dio_b_oe}) == 1);

    // R2: the driving pin and a quiet unused pin follow the strap.
    p_out_pin_r2: assert property (@(posedge clk) disable iff (rst)
        dir_fwd |-> (dio_b_oe && !dio_a_out));

    // R6: a cascade pulse only accompanies a presented pixel.
    p_fire_valid_r6: assert property (@(posedge clk) disable iff (rst)
        any_out |-> pix_valid);

    // R6: the cascade pulse never lasts two cycles.
    p_fire_single_r6: assert property (@(posedge clk) disable iff (rst)
        any_out |=> !any_out);

    // R9: the latch moves only on a strobe rising edge.
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$rose(ld_strobe) |=> $stable(line_q));

    // R10: the column selects move only on a strobe rising edge.
    p_sel_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$rose(ld_strobe) |=> $stable(col_hi));

    // R11: neighbouring columns sit in opposite reference groups.
    p_alternate_r11: assert property (@(posedge clk) disable iff (rst)
        col_hi[0] != col_hi[1]);

endmodule

bind col_line_loader col_line_loader_chk #(
    .NUM_PIX (NUM_PIX),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dir_fwd   (dir_fwd),
    .dio_a_out (dio_a_out),
    .dio_b_out (dio_b_out),
    .dio_a_oe  (dio_a_oe),
    .dio_b_oe  (dio_b_oe),
    .pix_valid (pix_valid),
    .ld_strobe (ld_strobe),
    .line_q    (line_q),
    .col_hi    (col_hi)
);

// File: tb/col_line_loader_bench.sv
module col_line_loader_bench;

    localparam int NP = 4;
    localparam int DW = 6;
    localparam int NC = 3 * NP;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dir_fwd = 1'b1;
    logic            dio_a_in = 1'b0;
    logic            dio_b_in = 1'b0;
    logic            dio_a_out, dio_b_out, dio_a_oe, dio_b_oe;
    logic            pix_valid = 1'b0;
    logic [3*DW-1:0] pix_data = '0;
    logic            ld_strobe = 1'b0;
    logic            pol_in = 1'b0;
    logic [NC*DW-1:0] line_q;
    logic [NC-1:0]   col_hi;

    int n_chk = 0;
    int n_bad = 0;
    int exp_buf   [NC];
    int exp_latch [NC];
    int exp_pol_next = 0;
    int exp_pol_cur  = 0;
    int hold = 0;
    bit pin_b = 1'b0;

    always #5 clk = ~clk;

    col_line_loader #(.NUM_PIX(NP), .DATA_W(DW)) u_col_line_loader (
        .clk(clk), .rst(rst), .dir_fwd(dir_fwd),
        .dio_a_in(dio_a_in), .dio_b_in(dio_b_in),
        .dio_a_out(dio_a_out), .dio_b_out(dio_b_out),
        .dio_a_oe(dio_a_oe), .dio_b_oe(dio_b_oe),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .ld_strobe(ld_strobe), .pol_in(pol_in),
        .line_q(line_q), .col_hi(col_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int subval(input int base, input int k, input int s);
        return (base * 11 + k * 5 + s * 17 + 3) & 63;
    endfunction

    task automatic check_latch(input string req);
        int bad_col = -1;
        for (int c = 0; c < NC; c++)
            if (bad_col < 0 && int'(line_q[c*DW +: DW]) != exp_latch[c]) bad_col = c;
        if (bad_col < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(line_q[bad_col*DW +: DW]), exp_latch[bad_col]);
    endtask

    task automatic check_sel(input string req);
        int bad_col = -1;
        for (int c = 0; c < NC; c++) begin
            int e = (c % 2 == 0) ? exp_pol_cur : 1 - exp_pol_cur;
            if (bad_col < 0 && int'(col_hi[c]) != e) bad_col = c;
        end
        if (bad_col < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(col_hi[bad_col]),
                 (bad_col % 2 == 0) ? exp_pol_cur : 1 - exp_pol_cur);
    endtask

    // Advance to the next falling edge and retire the start pulse when due.
    task automatic step();
        @(negedge clk);
        hold--;
        if (hold <= 0) begin
            dio_a_in = 1'b0;
            dio_b_in = 1'b0;
        end
    endtask

    function automatic int out_pin();
        return dir_fwd ? int'(dio_b_out) : int'(dio_a_out);
    endfunction

    // Start pulse on the strap's input pin, then n pixels with optional gaps.
    task automatic send_line(input bit fwd, input int plen, input int base,
                             input int n, input bit junk_at_start, input bit gaps);
        dir_fwd = fwd;
        hold = plen;
        if (fwd) dio_a_in = 1'b1; else dio_b_in = 1'b1;
        if (junk_at_start) begin
            pix_valid = 1'b1;
            pix_data  = '1;
        end
        step();
        pix_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (gaps && ((k + base) % 2 == 1)) begin
                pix_valid = 1'b0;
                step();
            end
            pix_valid = 1'b1;
            pix_data  = {DW'(subval(base, k, 0)), DW'(subval(base, k, 1)), DW'(subval(base, k, 2))};
            #1;
            if (k == NP - 1) chk(out_pin() == 1, "R6 cascade pulse on last pixel", out_pin(), 1);
            else if (k == 0) chk(out_pin() == 0, "R6 no cascade before last pixel", out_pin(), 0);
            for (int s = 0; s < 3; s++) begin
                int pos = fwd ? k : NP - 1 - k;
                exp_buf[3*pos + s] = subval(base, k, s);
            end
            step();
        end
        pix_valid = 1'b0;
        #1;
        chk(out_pin() == 0, "R6 cascade pulse one cycle", out_pin(), 0);
        step();
    endtask

    task automatic strobe_rise(input bit pol);
        ld_strobe = 1'b1;
        pol_in    = pol;
        @(negedge clk);
        exp_latch    = exp_buf;
        exp_pol_cur  = exp_pol_next;
        exp_pol_next = int'(pol);
    endtask

    task automatic strobe(input bit pol);
        strobe_rise(pol);
        ld_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            exp_buf[c] = 0;
            exp_latch[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state.
        check_latch("R1 latch cleared");
        check_sel("R1 low polarity pattern");
        chk(dio_a_out == 0 && dio_b_out == 0, "R1 no cascade out", int'(dio_a_out | dio_b_out), 0);
        // R2: pin roles for both strap values.
        chk(dio_b_oe == 1 && dio_a_oe == 0, "R2 forward pin roles", int'({dio_a_oe, dio_b_oe}), 1);
        dir_fwd = 1'b0;
        #1;
        chk(dio_a_oe == 1 && dio_b_oe == 0, "R2 reverse pin roles", int'({dio_a_oe, dio_b_oe}), 2);
        @(negedge clk);

        // R4: forward fill, one-cycle pulse, gaps between pixels.
        send_line(1'b1, 1, 1, NP, 1'b0, 1'b1);
        strobe(1'b1);
        check_latch("R4 forward fill order");
        check_sel("R10 first strobe applies reset polarity");

        // R5 and R3: reverse fill, two-cycle pulse, pixel on the start edge dropped.
        send_line(1'b0, 2, 2, NP, 1'b1, 1'b0);
        strobe(1'b0);
        check_latch("R5 reverse fill and R3 start-edge pixel dropped");
        check_sel("R10 R11 polarity from previous line");

        // R7: stray pixels with no load in progress.
        for (int k = 0; k < 3; k++) begin
            pix_valid = 1'b1;
            pix_data  = {3{DW'(k + 40)}};
            #1;
            chk(dio_a_out == 0 && dio_b_out == 0, "R7 no cascade while idle",
                int'(dio_a_out | dio_b_out), 0);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        @(negedge clk);
        strobe(1'b1);
        check_latch("R7 idle pixels ignored");
        check_sel("R10 polarity pipeline third line");

        // R2: pulse on the output-side pin starts nothing.
        dir_fwd = 1'b1;
        dio_b_in = 1'b1;
        @(negedge clk);
        dio_b_in = 1'b0;
        for (int k = 0; k < NP; k++) begin
            pix_valid = 1'b1;
            pix_data  = {3{DW'(k + 50)}};
            #1;
            chk(dio_b_out == 0, "R2 wrong pin starts no load", int'(dio_b_out), 0);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        @(negedge clk);
        strobe(1'b1);
        check_latch("R2 wrong pin leaves buffer unchanged");

        // R8: restart mid-line.
        send_line(1'b1, 1, 5, 2, 1'b0, 1'b0);
        send_line(1'b0, 1, 6, NP, 1'b0, 1'b1);
        strobe(1'b0);
        check_latch("R8 restart fills from slot 0");
        check_sel("R11 column groups after restart");

        // R9: strobe held high while a new line loads.
        strobe_rise(1'b1);
        send_line(1'b1, 2, 7, NP, 1'b0, 1'b0);
        check_latch("R9 held strobe makes no second copy");
        check_sel("R10 held strobe samples polarity once");
        ld_strobe = 1'b0;
        repeat (2) @(negedge clk);
        strobe(1'b0);
        check_latch("R9 next rising edge copies");

        // Sweep: both directions, pulse lengths, gap patterns and polarity patterns.
        for (int ln = 0; ln < 12; ln++) begin
            send_line(bit'(ln % 2), 1 + (ln / 2) % 2, 10 + ln, NP, bit'((ln / 3) % 2), bit'((ln / 4) % 2));
            strobe(bit'((ln * 5 / 3) % 2));
            check_latch(((ln % 2) == 1) ? "R4 sweep forward line" : "R5 sweep reverse line");
            check_sel("R10 R11 sweep polarity");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule